// File: doc/BRIEF.md
# SCSI Target Data-Phase Handshake Engine

This block is the target side of a SCSI data phase. It moves a fixed number of bytes over the asynchronous REQ/ACK handshake in either direction. A transfer starts with a one-cycle start pulse, which carries the direction, the byte count and an optional pause index.

In the send direction, bytes come in one at a time on a valid/ready stream. Each byte is placed on the data lines with odd parity and then offered to the initiator with REQ. In the receive direction, the engine requests each byte, waits a settle time after the initiator acknowledges it, samples the data lines and passes the byte out on a one-cycle valid strobe.

Every wait on ACK is guarded by a timeout and by the synchronised bus reset input. Either one ends the transfer early. A done pulse reports the number of bytes that completed.

Top module: `tgt_data_mover`

## Requirements
- R1: In send mode, the byte taken from the input stream is on `bus_dout_o` before REQ rises. REQ rises only after ACK has been sampled low. The data stays unchanged while REQ is high. REQ falls after ACK is sampled high. `in_ready_o` is high only while the engine waits for the next byte.
- R2: `bus_par_o` is always the inverse of the XOR of the eight bits on `bus_dout_o`, so the nine lines together carry an odd number of ones.
- R3: In send mode, after the final byte is acknowledged, `done_o` does not pulse until ACK has been sampled low.
- R4: When the 0-based index of the next send byte equals the pause index, REQ for that byte is held off for at least PAUSE_CYC cycles. A pause index equal to or greater than the byte count inserts no pause.
- R5: In receive mode, REQ rises and stays high until at least SETTLE_CYC cycles after ACK is sampled high. The byte on `bus_din_i` at the end of that settle time is presented on `rx_data_o` with a one-cycle `rx_valid_o`. The next REQ is raised only after ACK is sampled low.
- R6: A wait on ACK that lasts more than TIMEOUT_CYC cycles ends the transfer with a `done_o` pulse and REQ low.
- R7: `bus_rst_i` ends any ACK wait at the next clock edge. It takes priority over an ACK change seen in the same cycle.
- R8: `done_cnt_o` at `done_o` gives the completed bytes. A send byte counts once ACK has been seen high. A receive byte counts once ACK has been seen low after it.
- R9: `bus_oe_o` is high exactly while a send transfer is busy.
- R10: A byte count of zero produces `done_o` with count 0 and never raises REQ.
- R11: After reset, REQ, `bus_oe_o`, `busy_o`, `done_o` and `rx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse, accepted when idle |
| dir_send_i | input | 1 | 1 = send to initiator, 0 = receive |
| len_i | input | CW | Number of bytes to move |
| pause_at_i | input | CW | Index of the send byte preceded by a pause |
| in_data_i | input | 8 | Send byte stream data |
| in_valid_i | input | 1 | Send byte stream valid |
| in_ready_o | output | 1 | Send byte stream ready |
| ack_i | input | 1 | Synchronised ACK from the initiator |
| bus_rst_i | input | 1 | Synchronised bus reset |
| bus_din_i | input | 8 | Data lines as received |
| req_o | output | 1 | REQ to the initiator |
| bus_dout_o | output | 8 | Data lines to drive |
| bus_par_o | output | 1 | Odd parity line to drive |
| bus_oe_o | output | 1 | Output enable for data and parity |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| done_cnt_o | output | CW | Bytes completed |

## Verification
Two events can meet in one cycle: the initiator's ACK that would finish a byte, and the bus reset that aborts the wait. The bench provokes this by raising both in the same cycle while REQ is up for a chosen byte. It judges the result by whether `done_cnt_o` leaves that byte uncounted.

A second overlap is the pause landing on the byte right after the previous one completes, including index 0. The bench judges this from the REQ-low gap measured at the ports, against the same transfer with the pause index set beyond the count.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_GET,
        ST_SACKLO,
        ST_SACKHI,
        ST_TAIL,
        ST_RREQ,
        ST_SETTLE,
        ST_RACKLO,
        ST_DONE
    } tdm_state_e;
endpackage

// File: rtl/tdm_parity.sv
module tdm_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    output logic         odd_o
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_xor
        assign chain[g+1] = chain[g] ^ data_i[g];
    end
    assign odd_o = ~chain[W];
endmodule

// File: rtl/tdm_timer.sv
module tdm_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load_i)          cnt_q <= val_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tgt_data_mover.sv
module tgt_data_mover
    import tdm_pkg::*;
#(
    parameter int CW          = 16,
    parameter int PAUSE_CYC   = 25000,
    parameter int SETTLE_CYC  = 100,
    parameter int TIMEOUT_CYC = 750000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dir_send_i,
    input  logic [CW-1:0] len_i,
    input  logic [CW-1:0] pause_at_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    input  logic          ack_i,
    input  logic          bus_rst_i,
    input  logic [7:0]    bus_din_i,
    output logic          req_o,
    output logic [7:0]    bus_dout_o,
    output logic          bus_par_o,
    output logic          bus_oe_o,
    output logic [7:0]    rx_data_o,
    output logic          rx_valid_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] done_cnt_o
);
    localparam int MAX_AB = (PAUSE_CYC > SETTLE_CYC) ? PAUSE_CYC : SETTLE_CYC;
    localparam int MAXC   = (MAX_AB > TIMEOUT_CYC) ? MAX_AB : TIMEOUT_CYC;
    localparam int TW     = $clog2(MAXC + 1) + 1;

    typedef struct packed {
        tdm_state_e    st;
        logic          tx;
        logic [CW-1:0] idx;
        logic [CW-1:0] total;
        logic [CW-1:0] pause;
        logic [7:0]    dout;
        logic [7:0]    rxd;
        logic          rxv;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [CW-1:0] idx_inc;

    tdm_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    tdm_parity #(.W(8)) u_par (
        .data_i (r_q.dout),
        .odd_o  (bus_par_o)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rxv = 1'b0;
        idx_inc = r_q.idx + 1'b1;
        unique case (r_q.st)
            ST_IDLE: if (start_i) begin
                r_d.tx    = dir_send_i;
                r_d.total = len_i;
                r_d.pause = pause_at_i;
                r_d.idx   = '0;
                r_d.dout  = '0;
                if (len_i == '0)             r_d.st = ST_DONE;
                else if (!dir_send_i)        r_d.st = ST_RREQ;
                else if (pause_at_i == '0)   r_d.st = ST_PAUSE;
                else                         r_d.st = ST_GET;
            end
            ST_PAUSE: if (tmr_zero) r_d.st = ST_GET;
            ST_GET: if (in_valid_i) begin
                r_d.dout = in_data_i;
                r_d.st   = ST_SACKLO;
            end
            ST_SACKLO: begin
                if (bus_rst_i)      r_d.st = ST_DONE;
                else if (!ack_i)    r_d.st = ST_SACKHI;
                else if (tmr_zero)  r_d.st = ST_DONE;
            end
            ST_SACKHI: begin
                if (bus_rst_i) r_d.st = ST_DONE;
                else if (ack_i) begin
                    r_d.idx = idx_inc;
                    if (idx_inc == r_q.total)      r_d.st = ST_TAIL;
                    else if (idx_inc == r_q.pause) r_d.st = ST_PAUSE;
                    else                           r_d.st = ST_GET;
                end
                else if (tmr_zero) r_d.st = ST_DONE;
            end
            ST_TAIL: if (bus_rst_i || !ack_i || tmr_zero) r_d.st = ST_DONE;
            ST_RREQ: begin
                if (bus_rst_i)      r_d.st = ST_DONE;
                else if (ack_i)     r_d.st = ST_SETTLE;
                else if (tmr_zero)  r_d.st = ST_DONE;
            end
            ST_SETTLE: if (tmr_zero) begin
                r_d.rxd = bus_din_i;
                r_d.rxv = 1'b1;
                r_d.st  = ST_RACKLO;
            end
            ST_RACKLO: begin
                if (bus_rst_i) r_d.st = ST_DONE;
                else if (!ack_i) begin
                    r_d.idx = idx_inc;
                    r_d.st  = (idx_inc == r_q.total) ? ST_DONE : ST_RREQ;
                end
                else if (tmr_zero) r_d.st = ST_DONE;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase

        tmr_load = (r_d.st != r_q.st);
        if (r_d.st == ST_PAUSE)       tmr_val = TW'(PAUSE_CYC);
        else if (r_d.st == ST_SETTLE) tmr_val = TW'(SETTLE_CYC);
        else                          tmr_val = TW'(TIMEOUT_CYC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o = (r_q.st == ST_GET);
    assign req_o      = (r_q.st == ST_SACKHI) || (r_q.st == ST_RREQ) || (r_q.st == ST_SETTLE);
    assign bus_dout_o = r_q.dout;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign bus_oe_o   = busy_o && r_q.tx;
    assign rx_data_o  = r_q.rxd;
    assign rx_valid_o = r_q.rxv;
    assign done_o     = (r_q.st == ST_DONE);
    assign done_cnt_o = r_q.idx;
endmodule

// File: rtl/tdm_chk.sv
module tdm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_i,
    input logic       req_o,
    input logic [7:0] bus_dout_o,
    input logic       bus_par_o,
    input logic       bus_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       rx_valid_o
);
    AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_o) && bus_oe_o) |-> !$past(ack_i)); // R1
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o) && bus_oe_o) |-> $stable(bus_dout_o)); // R1
    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({bus_dout_o, bus_par_o}) % 2) == 1); // R2
    AST_RX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (!bus_oe_o && $past(req_o))); // R5
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_o); // R6
    AST_OE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> busy_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!req_o && !bus_oe_o && !rx_valid_o)); // R11
endmodule

bind tgt_data_mover tdm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .req_o      (req_o),
    .bus_dout_o (bus_dout_o),
    .bus_par_o  (bus_par_o),
    .bus_oe_o   (bus_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/tgt_data_mover_tb.sv
module tgt_data_mover_tb;
    localparam int CW = 8;
    localparam int PC = 40;
    localparam int SC = 3;
    localparam int TC = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0, dir_send = 1'b0;
    logic [CW-1:0] len = '0, pause_at = '0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0, in_ready;
    logic          ack = 1'b0, bus_rst = 1'b0;
    logic [7:0]    bus_din = '0;
    logic          req, bus_par, bus_oe, rx_valid, busy, done;
    logic [7:0]    bus_dout, rx_data;
    logic [CW-1:0] done_cnt;

    tgt_data_mover #(.CW(CW), .PAUSE_CYC(PC), .SETTLE_CYC(SC), .TIMEOUT_CYC(TC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dir_send_i(dir_send), .len_i(len),
        .pause_at_i(pause_at), .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .ack_i(ack), .bus_rst_i(bus_rst), .bus_din_i(bus_din), .req_o(req), .bus_dout_o(bus_dout),
        .bus_par_o(bus_par), .bus_oe_o(bus_oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .busy_o(busy), .done_o(done), .done_cnt_o(done_cnt));

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] b [0:31];
    logic [7:0] rxbuf [0:31];
    int rxn, maxgap, gap, minhi, hi, stall, req_rises, cnt_at_done;
    int v_order, v_tail, v_oe;
    bit done_seen, run_tx, req_prev, ack_pe, took;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit odd9(input logic [7:0] d, input logic p);
        return ($countones({d, p}) % 2) == 1;
    endfunction

    always @(posedge clk) begin
        ack_pe <= ack;
        took   <= in_valid && in_ready;
    end

    always @(negedge clk) begin
        if (req && !req_prev) begin
            req_rises++;
            if (gap > maxgap) maxgap = gap;
            gap = 0;
            stall = 0;
            if (bus_oe && ack_pe) v_order++;
        end
        if (!req) gap++;
        if (req) stall++;
        if (req && ack_pe) hi++;
        if (!req && req_prev && !run_tx) begin
            if (hi < minhi) minhi = hi;
        end
        if (!req) hi = 0;
        if (rx_valid) begin
            rxbuf[rxn] = rx_data;
            rxn++;
        end
        if (done && !done_seen) begin
            done_seen = 1;
            cnt_at_done = done_cnt;
            if (run_tx && ack_pe && !bus_rst) v_tail++;
        end
        if (rst_n && (bus_oe != (busy && run_tx))) v_oe++;
        req_prev = req;
    end

    // kind: 0 normal, 1 silent initiator (timeout), 2 bus reset, 3 bus reset with ACK
    task automatic run(input bit tx, input int n, input int pz, input int dmax,
                       input int stop_at, input int kind);
        for (int i = 0; i < n; i++) b[i] = 8'($urandom);
        done_seen = 0; rxn = 0; maxgap = 0; gap = 0; minhi = 999; hi = 0;
        req_rises = 0; v_order = 0; v_tail = 0; run_tx = tx;
        start = 1; dir_send = tx; len = CW'(n); pause_at = CW'(pz);
        tick();
        start = 0;
        fork
            begin
                if (tx) begin
                    for (int i = 0; i < n && !done_seen; i++) begin
                        repeat ($urandom_range(dmax)) tick();
                        in_valid = 1; in_data = b[i];
                        do tick(); while (!took && !done_seen);
                        in_valid = 0;
                    end
                end
            end
            begin
                for (int j = 0; j < n && !done_seen; j++) begin
                    while (!req && !done_seen) tick();
                    if (done_seen) break;
                    if (j == stop_at) begin
                        if (kind == 2) bus_rst = 1;
                        if (kind == 3) begin bus_rst = 1; ack = 1; end
                        while (!done_seen) tick();
                        bus_rst = 0; ack = 0;
                        break;
                    end
                    if (tx) begin
                        chk(bus_dout == b[j], "R1", "send byte on bus", bus_dout, b[j]);
                        chk(odd9(bus_dout, bus_par), "R2", "odd parity", bus_par, ~^bus_dout);
                    end
                    repeat ($urandom_range(dmax)) tick();
                    if (!tx) bus_din = b[j];
                    ack = 1;
                    while (req && !done_seen) tick();
                    repeat ($urandom_range(dmax)) tick();
                    ack = 0;
                    if (!tx) bus_din = 8'($urandom);
                end
            end
        join
        for (int g = 0; g < 2000 && !done_seen; g++) tick();
        tick(); tick();
        chk(done_seen, "R8", "done pulse seen", done_seen, 1);
        chk(!busy, "R8", "idle after done", busy, 0);
        if (stop_at < 0) begin
            chk(cnt_at_done == n, "R8", "completed count", cnt_at_done, n);
            chk(v_order == 0, "R1", "REQ rose with ACK high", v_order, 0);
            if (tx) chk(v_tail == 0, "R3", "done before ACK low", v_tail, 0);
            if (!tx) begin
                chk(rxn == n, "R5", "received byte count", rxn, n);
                for (int i = 0; i < n && i < rxn; i++)
                    chk(rxbuf[i] == b[i], "R5", "received byte", rxbuf[i], b[i]);
                if (n > 0) chk(minhi >= SC, "R5", "REQ held through settle", minhi, SC);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5C51));
        repeat (3) tick();
        @(negedge clk);
        chk(!req && !bus_oe && !busy && !done && !rx_valid, "R11", "outputs quiet in reset",
            {req, bus_oe, busy, done, rx_valid}, 0);
        rst_n = 1;
        tick(); tick();
        chk(!req && !busy, "R11", "quiet after reset", {req, busy}, 0);

        // directed send, no pause (pause index beyond count)
        run(1, 6, 20, 0, -1, 0);
        chk(maxgap < PC, "R4", "no pause when index >= count", maxgap, PC - 1);
        // pause at middle byte
        run(1, 6, 3, 0, -1, 0);
        chk(maxgap >= PC, "R4", "pause before byte 3", maxgap, PC);
        // pause at byte 0
        run(1, 4, 0, 0, -1, 0);
        chk(maxgap >= PC, "R4", "pause before byte 0", maxgap, PC);
        // pause index equal to count
        run(1, 5, 5, 0, -1, 0);
        chk(maxgap < PC, "R4", "no pause when index == count", maxgap, PC - 1);
        // slow ACK release exercises tail wait
        run(1, 3, 9, 4, -1, 0);
        // receive, directed
        run(0, 5, 9, 0, -1, 0);
        run(0, 4, 9, 3, -1, 0);
        // zero count
        run(1, 0, 0, 0, -1, 0);
        chk(req_rises == 0, "R10", "no REQ with zero count", req_rises, 0);
        chk(cnt_at_done == 0, "R10", "zero count done", cnt_at_done, 0);
        run(0, 0, 0, 0, -1, 0);
        chk(req_rises == 0, "R10", "no REQ with zero count receive", req_rises, 0);
        // timeout in receive after two bytes
        run(0, 5, 9, 1, 2, 1);
        chk(cnt_at_done == 2, "R6", "count at timeout", cnt_at_done, 2);
        chk(stall >= TC && stall <= TC + 3, "R6", "timeout length", stall, TC);
        // timeout in send
        run(1, 4, 9, 1, 1, 1);
        chk(cnt_at_done == 1, "R6", "send count at timeout", cnt_at_done, 1);
        chk(stall >= TC && stall <= TC + 3, "R6", "send timeout length", stall, TC);
        // bus reset alone
        run(1, 5, 9, 1, 2, 2);
        chk(cnt_at_done == 2, "R7", "count at bus reset", cnt_at_done, 2);
        chk(stall <= 3, "R7", "bus reset ends wait quickly", stall, 2);
        // bus reset together with ACK: reset wins, byte not counted
        run(1, 5, 9, 0, 3, 3);
        chk(cnt_at_done == 3, "R7", "reset beats ACK in send", cnt_at_done, 3);
        run(0, 5, 9, 0, 1, 3);
        chk(cnt_at_done == 1, "R7", "reset beats ACK in receive", cnt_at_done, 1);
        chk(rxn == 1, "R7", "no byte sampled after reset", rxn, 1);
        // random mix
        for (int k = 0; k < 12; k++) begin
            bit tx;
            int n;
            tx = 1'($urandom);
            n = $urandom_range(10, 1);
            run(tx, n, $urandom_range(12), 3, -1, 0);
        end
        chk(v_oe == 0, "R9", "output enable tracks send busy", v_oe, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule